// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level page table from memory. A request carries the address, a write flag and a user flag. The control settings are sampled at the moment the request is accepted: paging on or off, supervisor write protection, large-page enable, the address-bit-20 gate and the directory base. The walker then reads the directory entry and, for a 4 KB page, the table entry, over a word-wide memory port with a valid/ready request side and a separate read-data strobe.

A walk that succeeds ends with a one-cycle `done` pulse. The physical address and a write-permission flag are held on the result outputs. A walk that fails ends with a one-cycle `fault` pulse and a three-bit error code. Accessed and dirty bits are updated in memory by read-modify-write, and every such write completes before the ending pulse. Only one walk is in flight at a time. `req_ready` is high only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: With paging off, a request completes with `done` in the cycle after it is accepted. It makes no memory access, returns the linear address ANDed with the A20 mask, and grants write.
- R2: The directory entry is read from ({base[31:12], 12'b0} + linear[31:22]*4) AND the A20 mask.
- R3: For a 4 KB page the table entry is read from ({pde[31:12], 12'b0} + linear[21:12]*4) AND the A20 mask.
- R4: When the directory entry has its page-size bit (bit 7) set and large pages are enabled, the walk stops at that entry. The physical address is then {pde[31:22], linear[21:0]}. When large pages are disabled, the same entry is treated as a pointer to a table.
- R5: For a 4 KB page, the user bit (bit 2) and the read/write bit (bit 1) that take effect are the AND of the directory and table entry bits.
- R6: A user access faults when the effective user bit is 0. A user write faults when the effective read/write bit is 0. A supervisor write faults on a 0 read/write bit only while write protection is on.
- R7: On success the final entry gets the accessed bit (bit 5) set, and on a write also the dirty bit (bit 6). It is written back only if this changes its value.
- R8: On the 4 KB path, a directory entry whose accessed bit is 0 is rewritten with only that bit set, before the table read. Its dirty bit is never written.
- R9: The fault code is {user, write, kind}. Kind is 1 for a protection violation and 0 for a not-present entry (present bit 0 clear).
- R10: `res_write` is 1 only when the final entry, after update, is dirty. For a user access it also needs the effective read/write bit. For a supervisor access it needs write protection off or the effective read/write bit.
- R11: The A20 mask is 32'hFFEF_FFFF while the gate is off and all ones while it is on. It applies to both table fetches and to the final physical address.
- R12: `req_ready` is low from acceptance until after the end pulse. A memory request holds its address and kind until `mem_ready`. Reads return on `mem_rvalid` one or more cycles later. `done` and `fault` never coincide.
- R13: Entry bits used: present 0, read/write 1, user 2, accessed 5, dirty 6, page size 7. Write-back data is the read entry with only accessed and dirty bits added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| ctl_paging | input | 1 | Paging enabled |
| ctl_wp | input | 1 | Supervisor write protection |
| ctl_pse | input | 1 | Large (4 MB) pages enabled |
| ctl_a20 | input | 1 | Address bit 20 gate open |
| ctl_dir_base | input | 32 | Page directory base |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk succeeded (one cycle) |
| fault | output | 1 | Walk faulted (one cycle) |
| res_paddr | output | 32 | Physical address |
| res_write | output | 1 | Write permitted |
| fault_code | output | 3 | {user, write, protection} |

## Verification
Stimulus comes from a set of fresh table images that mix present, absent, clean, accessed, dirty, read-only and supervisor-only entries at both levels. These images are walked with every combination of user and supervisor, read and write, and protection on and off. Walks on the same entry that differ in one request bit separate fault from success, separate the two fault kinds, and show whether write permission follows the dirty bit. The counts of memory reads and writes show whether a write-back happened and whether an accessed bit that was already set was left alone. Large-page and pointer readings of one directory entry, together with a gate-closed walk from a base that has bit 20 set, show that the page-size enable and the A20 mask act on the fetch addresses and on the result.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW = 32,
  parameter logic [AW-1:0] A20_OFF_MASK = 32'hFFEF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_user,
  input  logic          ctl_paging,
  input  logic          ctl_wp,
  input  logic          ctl_pse,
  input  logic          ctl_a20,
  input  logic [AW-1:0] ctl_dir_base,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] res_paddr,
  output logic          res_write,
  output logic [2:0]    fault_code
);
  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_US = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;
  localparam int PG   = 12;
  localparam int IXW  = 10;
  localparam int BIG  = PG + IXW;

  typedef enum logic [2:0] {S_IDLE, S_DRD, S_DWT, S_TRD, S_TWT, S_WB, S_RSP} st_t;

  st_t st;
  logic [AW-1:0] lin, dbase, msk, pde, wb_addr, wb_data, pa;
  logic wr, usr, wp, pse, wb_tbl, rw_ok, flt;
  logic [2:0] code;

  logic [AW-1:0] dir_addr, tbl_addr, ent, upd, page_pa, msk_in;
  logic big, us_e, rw_e, prot_f, chg, perm_w, in_tbl;

  assign msk_in   = ctl_a20 ? '1 : A20_OFF_MASK;
  assign dir_addr = ({dbase[AW-1:PG], {PG{1'b0}}} +
                     {{(AW-IXW-2){1'b0}}, lin[AW-1:BIG], 2'b00}) & msk;
  assign tbl_addr = ({pde[AW-1:PG], {PG{1'b0}}} +
                     {{(AW-IXW-2){1'b0}}, lin[BIG-1:PG], 2'b00}) & msk;

  assign ent    = mem_rdata;
  assign in_tbl = (st == S_TWT);
  assign big    = ent[B_PS] & pse;
  assign us_e   = ent[B_US] & (in_tbl ? pde[B_US] : 1'b1);
  assign rw_e   = ent[B_RW] & (in_tbl ? pde[B_RW] : 1'b1);
  assign prot_f = (usr & ~us_e) | (wr & ~rw_e & (usr | wp));
  assign upd    = ent | (AW'(1) << B_A) | (AW'(wr) << B_D);
  assign chg    = (upd != ent);
  assign perm_w = upd[B_D] & (usr ? rw_e : (~wp | rw_e));
  assign page_pa = (in_tbl ? {ent[AW-1:PG], lin[PG-1:0]}
                           : {ent[AW-1:BIG], lin[BIG-1:0]}) & msk;

  assign req_ready  = (st == S_IDLE);
  assign mem_valid  = (st == S_DRD) || (st == S_TRD) || (st == S_WB);
  assign mem_we     = (st == S_WB);
  assign mem_addr   = (st == S_WB) ? wb_addr : (st == S_TRD) ? tbl_addr : dir_addr;
  assign mem_wdata  = wb_data;
  assign done       = (st == S_RSP) && !flt;
  assign fault      = (st == S_RSP) && flt;
  assign res_paddr  = pa;
  assign res_write  = rw_ok;
  assign fault_code = code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lin <= '0; dbase <= '0; msk <= '1; pde <= '0;
      wb_addr <= '0; wb_data <= '0; pa <= '0;
      wr <= 1'b0; usr <= 1'b0; wp <= 1'b0; pse <= 1'b0;
      wb_tbl <= 1'b0; rw_ok <= 1'b0; flt <= 1'b0; code <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin <= req_addr; wr <= req_write; usr <= req_user;
          wp <= ctl_wp; pse <= ctl_pse; dbase <= ctl_dir_base; msk <= msk_in;
          if (ctl_paging) st <= S_DRD;
          else begin
            pa <= req_addr & msk_in; rw_ok <= 1'b1; flt <= 1'b0; st <= S_RSP;
          end
        end
        S_DRD: if (mem_ready) st <= S_DWT;
        S_DWT: if (mem_rvalid) begin
          pde <= ent;
          if (!ent[B_P]) begin
            flt <= 1'b1; code <= {usr, wr, 1'b0}; st <= S_RSP;
          end else if (big) begin
            if (prot_f) begin
              flt <= 1'b1; code <= {usr, wr, 1'b1}; st <= S_RSP;
            end else begin
              flt <= 1'b0; pa <= page_pa; rw_ok <= perm_w;
              wb_addr <= dir_addr; wb_data <= upd; wb_tbl <= 1'b0;
              st <= chg ? S_WB : S_RSP;
            end
          end else if (!ent[B_A]) begin
            wb_addr <= dir_addr; wb_data <= ent | (AW'(1) << B_A);
            wb_tbl <= 1'b1; st <= S_WB;
          end else st <= S_TRD;
        end
        S_TRD: if (mem_ready) st <= S_TWT;
        S_TWT: if (mem_rvalid) begin
          if (!ent[B_P]) begin
            flt <= 1'b1; code <= {usr, wr, 1'b0}; st <= S_RSP;
          end else if (prot_f) begin
            flt <= 1'b1; code <= {usr, wr, 1'b1}; st <= S_RSP;
          end else begin
            flt <= 1'b0; pa <= page_pa; rw_ok <= perm_w;
            wb_addr <= tbl_addr; wb_data <= upd; wb_tbl <= 1'b0;
            st <= chg ? S_WB : S_RSP;
          end
        end
        S_WB: if (mem_ready) st <= wb_tbl ? S_TRD : S_RSP;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        ctl_paging,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic        fault
);
  a_r1_direct: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !ctl_paging |=> done && !mem_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

  a_r12_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !req_ready && !mem_valid);

  a_r12_back: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> req_ready);

  a_r13_wb_acc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[5] && mem_wdata[0]);

  a_r2_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic ctl_paging = 1'b0, ctl_wp = 1'b0, ctl_pse = 1'b0, ctl_a20 = 1'b1;
  logic [31:0] req_addr = '0, ctl_dir_base = '0;
  logic req_ready, mem_valid, mem_we, done, fault, res_write;
  logic [31:0] mem_addr, mem_wdata, res_paddr;
  logic [2:0] fault_code;
  logic mem_ready, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_user(req_user),
    .ctl_paging(ctl_paging), .ctl_wp(ctl_wp), .ctl_pse(ctl_pse), .ctl_a20(ctl_a20),
    .ctl_dir_base(ctl_dir_base), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .res_paddr(res_paddr), .res_write(res_write), .fault_code(fault_code));

  // memory model: 16 KB, zero outside, stalls one cycle in four
  logic [31:0] mem [0:4095];
  logic [1:0] tick = '0;
  logic pend = 1'b0, dly = 1'b0, ld_en = 1'b0;
  logic [31:0] rdat = '0, ld_a = '0, ld_d = '0;
  int nrd = 0, nwr = 0;
  assign mem_ready = (tick != 2'd3);

  always @(posedge clk) begin
    tick <= tick + 2'd1;
    mem_rvalid <= 1'b0;
    if (ld_en) mem[ld_a[13:2]] <= ld_d;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        if (mem_addr[31:14] == '0) mem[mem_addr[13:2]] <= mem_wdata;
        nwr <= nwr + 1;
      end else begin
        pend <= 1'b1; dly <= tick[0];
        rdat <= (mem_addr[31:14] == '0) ? mem[mem_addr[13:2]] : '0;
        nrd <= nrd + 1;
      end
    end
    if (pend) begin
      if (!dly) begin pend <= 1'b0; mem_rvalid <= 1'b1; mem_rdata <= rdat; end
      else dly <= 1'b0;
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  bit ended = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !ended) begin
      ended = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: got hung walk expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); ld_en = 1'b1; ld_a = a; ld_d = d;
  endtask

  task automatic init_tables();
    poke(32'h1000, 32'h0000_2007); poke(32'h1004, 32'h0000_3025);
    poke(32'h1008, 32'h0);         poke(32'h100C, 32'h0840_00E3);
    poke(32'h1010, 32'h1040_0087); poke(32'h2000, 32'h0001_0067);
    poke(32'h2004, 32'h0002_0007); poke(32'h2008, 32'h0);
    poke(32'h200C, 32'h0013_0065); poke(32'h2010, 32'h0005_0023);
    poke(32'h3000, 32'h0006_0067);
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic walk(input logic [31:0] la, input logic [31:0] base, input logic w, input logic u,
                      input logic pg, input logic wpp, input logic ps, input logic a20, output bit ok);
    int n = 0;
    @(negedge clk);
    req_addr = la; ctl_dir_base = base; req_write = w; req_user = u;
    ctl_paging = pg; ctl_wp = wpp; ctl_pse = ps; ctl_a20 = a20; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!(done || fault) && n < 2000) begin @(negedge clk); n++; end
    ok = (n < 2000);
  endtask

  typedef struct packed {
    logic [31:0] la; logic [31:0] base;
    logic w, u, pg, wp, ps, a20;
    logic flt; logic [2:0] code; logic [31:0] pa; logic rw;
    logic [1:0] nr; logic [1:0] nw; logic [3:0] rq;
  } vec_t;

  localparam vec_t VEC [0:22] = '{
    '{32'h1234_5ABC, 32'h1000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h1234_5ABC,1'b1, 2'd0,2'd0, 4'd1},
    '{32'h0010_0ABC, 32'h1000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,3'd0, 32'h0000_0ABC,1'b1, 2'd0,2'd0, 4'd11},
    '{32'h0000_0ABC, 32'h1000, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0001_0ABC,1'b1, 2'd2,2'd1, 4'd3},
    '{32'h0000_1ABC, 32'h1000, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0002_0ABC,1'b1, 2'd2,2'd2, 4'd7},
    '{32'h0000_1ABC, 32'h1000, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0002_0ABC,1'b0, 2'd2,2'd2, 4'd10},
    '{32'h0000_2ABC, 32'h1000, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b1,3'b000, 32'h0,1'b0, 2'd2,2'd1, 4'd9},
    '{32'h0000_2ABC, 32'h1000, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,3'b110, 32'h0,1'b0, 2'd2,2'd1, 4'd9},
    '{32'h0000_3ABC, 32'h1000, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,3'b111, 32'h0,1'b0, 2'd2,2'd1, 4'd6},
    '{32'h0000_3ABC, 32'h1000, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0013_0ABC,1'b1, 2'd2,2'd1, 4'd6},
    '{32'h0000_3ABC, 32'h1000, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,3'b011, 32'h0,1'b0, 2'd2,2'd1, 4'd6},
    '{32'h0000_4ABC, 32'h1000, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,3'b101, 32'h0,1'b0, 2'd2,2'd1, 4'd6},
    '{32'h0000_4ABC, 32'h1000, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0005_0ABC,1'b0, 2'd2,2'd1, 4'd10},
    '{32'h0000_4ABC, 32'h1000, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0005_0ABC,1'b1, 2'd2,2'd2, 4'd7},
    '{32'h0040_0ABC, 32'h1000, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0006_0ABC,1'b0, 2'd2,2'd0, 4'd5},
    '{32'h0040_0ABC, 32'h1000, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,3'b111, 32'h0,1'b0, 2'd2,2'd0, 4'd5},
    '{32'h0040_0ABC, 32'h1000, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0006_0ABC,1'b1, 2'd2,2'd0, 4'd5},
    '{32'h0080_0ABC, 32'h1000, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,3'b100, 32'h0,1'b0, 2'd1,2'd0, 4'd9},
    '{32'h00C1_2ABC, 32'h1000, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0841_2ABC,1'b1, 2'd1,2'd0, 4'd4},
    '{32'h00C1_2ABC, 32'h1000, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,3'b101, 32'h0,1'b0, 2'd1,2'd0, 4'd4},
    '{32'h00C1_2ABC, 32'h1000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b1,3'b000, 32'h0,1'b0, 2'd2,2'd0, 4'd4},
    '{32'h0110_0ABC, 32'h1000, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,3'd0, 32'h1040_0ABC,1'b1, 2'd1,2'd1, 4'd11},
    '{32'h0110_0ABC, 32'h1000, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h1050_0ABC,1'b1, 2'd1,2'd1, 4'd11},
    '{32'h0000_0ABC, 32'h0010_1000, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,3'd0, 32'h0001_0ABC,1'b1, 2'd2,2'd1, 4'd2}
  };

  initial begin
    bit ok;
    int r0, w0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R12", "no memory request in reset", {31'b0, mem_valid}, 32'd0);
    chk("R12", "no end pulse in reset", {30'b0, done, fault}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 23; i++) begin
      init_tables();
      r0 = nrd; w0 = nwr;
      walk(VEC[i].la, VEC[i].base, VEC[i].w, VEC[i].u, VEC[i].pg, VEC[i].wp, VEC[i].ps, VEC[i].a20, ok);
      chk(rname(VEC[i].rq), $sformatf("vec %0d completes", i), {31'b0, ok}, 32'd1);
      chk(rname(VEC[i].rq), $sformatf("vec %0d fault", i), {31'b0, fault}, {31'b0, VEC[i].flt});
      if (VEC[i].flt)
        chk("R9", $sformatf("vec %0d code", i), {29'b0, fault_code}, {29'b0, VEC[i].code});
      else begin
        chk(rname(VEC[i].rq), $sformatf("vec %0d paddr", i), res_paddr, VEC[i].pa);
        chk("R10", $sformatf("vec %0d write perm", i), {31'b0, res_write}, {31'b0, VEC[i].rw});
      end
      chk(rname(VEC[i].rq), $sformatf("vec %0d reads", i), nrd - r0, {30'b0, VEC[i].nr});
      chk("R7", $sformatf("vec %0d write-backs", i), nwr - w0, {30'b0, VEC[i].nw});
    end

    // R8 and R13: contents written back by a user write through a clean 4 KB path
    init_tables();
    walk(32'h0000_1ABC, 32'h1000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, ok);
    chk("R8", "directory entry gets accessed only", mem[12'h400], 32'h0000_2027);
    chk("R13", "table entry gets accessed and dirty", mem[12'h801], 32'h0002_0067);

    // R12: request refused while busy
    init_tables();
    @(negedge clk);
    req_addr = 32'h0000_0ABC; ctl_dir_base = 32'h1000; req_write = 1'b0; req_user = 1'b1;
    ctl_paging = 1'b1; ctl_wp = 1'b0; ctl_pse = 1'b1; ctl_a20 = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    chk("R12", "ready low during walk", {31'b0, req_ready}, 32'd0);
    req_valid = 1'b0;
    for (int n = 0; n < 2000 && !(done || fault); n++) @(negedge clk);
    chk("R12", "walk ends with done", {31'b0, done}, 32'd1);
    @(negedge clk);
    chk("R12", "ready after end pulse", {31'b0, req_ready}, 32'd1);

    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule